// File: doc/BRIEF.md
# Buffered 16-bit Timer with Trigger Reset

This block is a 16-bit up-counter that software reaches through an 8-bit register bus. The count is split into a low-byte and a high-byte address. It advances on prescaled tick-enable cycles while the run bit is set. When the count wraps from all ones to zero, a sticky overflow flag is set. An interrupt line follows that flag whenever the interrupt enable bit is set.

An optional buffered access mode lets software move all 16 bits in one step. In this mode the high-byte address is served by a shadow register and never by the live high byte. Reading the low byte captures the live high byte into the shadow. A high-byte write only loads the shadow, and the next low-byte write then commits both bytes together.

An external compare trigger pulse clears the count to zero, so the compare value acts as the timer period. The trigger never sets the overflow flag. It loses to a software write to either timer address in the same cycle.

Top module: `tmr16_unit`

## Requirements
- R1: The count rises by one on each step and wraps from 0xFFFF to 0x0000. A step happens only on a cycle where run (control bit 0) is set, tick_en is high and the prescaler is at terminal count.
- R2: Control bits 5:4 select the prescale ratio: 00 = 1, 01 = 2, 10 = 4, 11 = 8 tick-enable cycles per step. With run clear, tick_en has no effect.
- R3: The wrap sets a sticky overflow flag, read at address 3 bit 0 and driven on ovf_flag. The irq output is high exactly when that flag and the enable bit (address 3 bit 1) are both set.
- R4: Writing address 3 with bit 0 = 0 clears the flag, and writing bit 0 = 1 leaves it as it is. If a wrap happens in the same cycle as a clearing write, the flag stays set.
- R5: With buffered mode off (control bit 7 = 0), address 0 reads and writes the live low byte and address 1 reads and writes the live high byte.
- R6: With buffered mode on, address 1 reads the shadow register. A read of address 0 copies the live high byte into the shadow at the end of that access.
- R7: With buffered mode on, a write to address 1 loads only the shadow. A write to address 0 loads the low byte and moves the shadow into the high byte in the same cycle.
- R8: A write to address 0 clears the prescaler. A write to address 1 does not.
- R9: A pulse on evt_trig clears the count to zero. It does not set the overflow flag, even when the count is 0xFFFF and a step is due.
- R10: A write to address 0 or 1 in the same cycle as evt_trig takes effect, and the trigger is ignored for that cycle.
- R11: Control bit 3 is a stored bit that reads back as written and has no effect on counting. Address 2 reads {bit7 buffered, 0, bits5:4 prescale, bit3 stored, 0, 0, bit0 run}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only; data is always driven) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| tick_en | input | 1 | Count enable tick |
| evt_trig | input | 1 | Compare special-event trigger pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
Several behaviours are checked by assertions on every cycle: the wrap to zero, the trigger clearing the count without raising the flag, the write winning over a trigger, the high byte staying put on a buffered high write, and the flag's stickiness. Only the bench scenarios can show the rest. These are the step counts produced by each prescale ratio, the value the shadow captures while the count is moving, and the flag surviving a same-cycle clear. They also include the difference between low and high writes on prescaler phase and the data read back through each address in both access modes.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int SW = 2;

  typedef enum logic [1:0] {
    ADR_LO  = 2'd0,
    ADR_HI  = 2'd1,
    ADR_CTL = 2'd2,
    ADR_STS = 2'd3
  } reg_addr_e;

  localparam int CB_RUN  = 0;
  localparam int CB_OSC  = 3;
  localparam int CB_PSLO = 4;
  localparam int CB_BUF  = 7;
  localparam int SB_FLAG = 0;
  localparam int SB_IEN  = 1;
endpackage

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic [SW-1:0] sel,
  input  logic          clr,
  output logic          step
);
  localparam int PW = (1 << SW) - 1;

  logic [PW-1:0] pcnt, pcnt_nx, lim;
  logic          adv;

  always_comb begin
    lim  = PW'((32'd1 << sel) - 32'd1);
    adv  = run && tick_en;
    step = adv && (pcnt >= lim);
    if (clr)       pcnt_nx = '0;
    else if (step) pcnt_nx = '0;
    else if (adv)  pcnt_nx = pcnt + 1'b1;
    else           pcnt_nx = pcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt_nx;
  end

  // R8: a low-byte write restarts the prescale phase
  assert_presc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_mode,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            rd_lo,
  input  logic [DW-1:0]   wdata,
  input  logic            trig,
  input  logic            step,
  output logic [2*DW-1:0] cnt,
  output logic [DW-1:0]   shadow,
  output logic            wrap
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_nx;
  logic [DW-1:0] shd_nx;
  logic          sw_wr;

  always_comb begin
    sw_wr  = wr_lo || wr_hi;
    cnt_nx = cnt;
    shd_nx = shadow;
    wrap   = 1'b0;
    if (buf_mode && rd_lo) shd_nx = cnt[CW-1:DW];
    if (wr_lo) begin
      cnt_nx[DW-1:0] = wdata;
      if (buf_mode) cnt_nx[CW-1:DW] = shadow;
    end
    if (wr_hi) begin
      if (buf_mode) shd_nx = wdata;
      else          cnt_nx[CW-1:DW] = wdata;
    end
    if (!sw_wr) begin
      if (trig) begin
        cnt_nx = '0;
      end else if (step) begin
        cnt_nx = cnt + 1'b1;
        wrap   = (cnt == {CW{1'b1}});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shadow <= '0;
    end else begin
      cnt    <= cnt_nx;
      shadow <= shd_nx;
    end
  end

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trig && !sw_wr && cnt == {CW{1'b1}}) |=> (cnt == '0));

  assert_trig_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !sw_wr) |=> (cnt == '0));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && wr_lo) |=> (cnt[DW-1:0] == $past(wdata)));

  assert_hi_shadow_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_hi && !wr_lo) |=> $stable(cnt[CW-1:DW]));
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_en,
  input  logic          evt_trig,
  output logic          ovf_flag,
  output logic          irq
);
  logic          run_q, osc_q, buf_q, ien_q, flag_q;
  logic [SW-1:0] psel_q;
  logic          run_nx, osc_nx, buf_nx, ien_nx, flag_nx;
  logic [SW-1:0] psel_nx;
  logic          wr_lo, wr_hi, wr_ctl, wr_sts, rd_lo;
  logic          step, wrap;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shadow;

  always_comb begin
    wr_lo  = bus_wr && (bus_sel == ADR_LO);
    wr_hi  = bus_wr && (bus_sel == ADR_HI);
    wr_ctl = bus_wr && (bus_sel == ADR_CTL);
    wr_sts = bus_wr && (bus_sel == ADR_STS);
    rd_lo  = bus_rd && (bus_sel == ADR_LO);
  end

  tmr16_presc #(.SW(SW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .tick_en (tick_en),
    .sel     (psel_q),
    .clr     (wr_lo),
    .step    (step)
  );

  tmr16_count #(.DW(DW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .buf_mode (buf_q),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rd_lo    (rd_lo),
    .wdata    (bus_wdata),
    .trig     (evt_trig),
    .step     (step),
    .cnt      (cnt),
    .shadow   (shadow),
    .wrap     (wrap)
  );

  always_comb begin
    run_nx  = run_q;
    osc_nx  = osc_q;
    buf_nx  = buf_q;
    psel_nx = psel_q;
    ien_nx  = ien_q;
    flag_nx = flag_q;
    if (wr_ctl) begin
      run_nx  = bus_wdata[CB_RUN];
      osc_nx  = bus_wdata[CB_OSC];
      buf_nx  = bus_wdata[CB_BUF];
      psel_nx = bus_wdata[CB_PSLO +: SW];
    end
    if (wr_sts) begin
      ien_nx = bus_wdata[SB_IEN];
      if (!bus_wdata[SB_FLAG]) flag_nx = 1'b0;
    end
    if (wrap) flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      osc_q  <= 1'b0;
      buf_q  <= 1'b0;
      psel_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_nx;
      osc_q  <= osc_nx;
      buf_q  <= buf_nx;
      psel_q <= psel_nx;
      ien_q  <= ien_nx;
      flag_q <= flag_nx;
    end
  end

  always_comb begin
    unique case (bus_sel)
      ADR_LO:  bus_rdata = cnt[DW-1:0];
      ADR_HI:  bus_rdata = buf_q ? shadow : cnt[CW-1:DW];
      ADR_CTL: bus_rdata = {buf_q, 1'b0, psel_q, osc_q, 2'b00, run_q};
      default: bus_rdata = {6'b0, ien_q, flag_q};
    endcase
  end

  assign ovf_flag = flag_q;
  assign irq      = flag_q && ien_q;

  assert_trig_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_trig && !ovf_flag) |=> !ovf_flag);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_sts && !bus_wdata[SB_FLAG])) |=> ovf_flag);

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

// File: tb/tmr16_unit_tb.sv
module tmr16_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_sel;
  logic       bus_wr, bus_rd, tick_en, evt_trig;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ovf_flag, irq;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] q;

  always #2.5 clk = ~clk;

  tmr16_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .evt_trig(evt_trig), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    do_rd(2'd0, lo);
    do_rd(2'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_sel = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tick_en = 0; evt_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    for (int a = 0; a < 4; a++) begin
      do_rd(a[1:0], q);
      chk("reset regs", {8'h0, q}, 16'h0);
    end
    chk("reset irq", {15'h0, irq}, 16'h0);

    // R11: stored bit, no counting effect
    do_wr(2'd2, 8'h08);
    do_rd(2'd2, q);
    chk("R11 ctrl readback", {8'h0, q}, 16'h0008);
    ticks(6);
    rd16(v);
    chk("R11 no count", v, 16'h0000);

    // R5: unbuffered direct access
    do_wr(2'd0, 8'h34);
    do_wr(2'd1, 8'h12);
    rd16(v);
    chk("R5 direct rw", v, 16'h1234);

    // R2: prescale sweep, plus run gating
    for (int ps = 0; ps < 4; ps++) begin
      do_wr(2'd0, 8'h00);
      do_wr(2'd1, 8'h00);
      do_wr(2'd2, 8'h01 | 8'(ps << 4));
      ticks(20);
      rd16(v);
      chk("R2 prescale count", v, 16'(20 >> ps));
    end
    do_wr(2'd2, 8'h00);
    ticks(5);
    rd16(v);
    chk("R2 run off", v, 16'(20 >> 3));

    // R1 wrap, R3 flag and irq
    do_wr(2'd2, 8'h01);
    do_wr(2'd0, 8'hFE);
    do_wr(2'd1, 8'hFF);
    ticks(2);
    rd16(v);
    chk("R1 wrap", v, 16'h0000);
    do_rd(2'd3, q);
    chk("R3 flag set", {8'h0, q}, 16'h0001);
    chk("R3 irq masked", {15'h0, irq}, 16'h0);
    do_wr(2'd3, 8'h03);
    chk("R3 irq enabled", {14'h0, ovf_flag, irq}, 16'h0003);
    do_wr(2'd3, 8'h02);
    chk("R4 clear", {14'h0, ovf_flag, irq}, 16'h0000);

    // R4: wrap and clear in the same cycle
    do_wr(2'd0, 8'hFF);
    do_wr(2'd1, 8'hFF);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 2'd3; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    chk("R4 wrap beats clear", {15'h0, ovf_flag}, 16'h1);
    do_wr(2'd3, 8'h00);
    chk("R4 cleared", {15'h0, ovf_flag}, 16'h0);

    // R9: trigger clears, no flag even at 0xFFFF with step due
    do_wr(2'd0, 8'hFF);
    do_wr(2'd1, 8'hFF);
    @(negedge clk);
    evt_trig = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    evt_trig = 1'b0; tick_en = 1'b0;
    chk("R9 no flag", {15'h0, ovf_flag}, 16'h0);
    rd16(v);
    chk("R9 trig clear", v, 16'h0000);

    // R10: write wins over trigger
    do_wr(2'd0, 8'h34);
    do_wr(2'd1, 8'h12);
    @(negedge clk);
    evt_trig = 1'b1; bus_sel = 2'd0; bus_wdata = 8'h55; bus_wr = 1'b1;
    @(negedge clk);
    evt_trig = 1'b0; bus_wr = 1'b0;
    rd16(v);
    chk("R10 write wins", v, 16'h1255);

    // R8: low write clears prescaler, high write does not (div 8)
    do_wr(2'd2, 8'h31);
    do_wr(2'd1, 8'h00);
    do_wr(2'd0, 8'h00);
    ticks(5);
    do_wr(2'd1, 8'h00);
    ticks(3);
    rd16(v);
    chk("R8 high write keeps phase", v, 16'h0001);
    do_wr(2'd0, 8'h00);
    ticks(5);
    do_wr(2'd0, 8'h00);
    ticks(3);
    rd16(v);
    chk("R8 low write clears phase", v, 16'h0000);

    // R6/R7: buffered access
    do_wr(2'd2, 8'h00);
    do_wr(2'd0, 8'h00);
    do_wr(2'd1, 8'h5A);
    do_wr(2'd2, 8'h80);
    do_wr(2'd1, 8'h11);
    do_rd(2'd1, q);
    chk("R6 hi reads shadow", {8'h0, q}, 16'h0011);
    do_wr(2'd2, 8'h00);
    do_rd(2'd1, q);
    chk("R7 live hi untouched", {8'h0, q}, 16'h005A);
    do_wr(2'd2, 8'h80);
    do_rd(2'd0, q);
    chk("R6 lo read", {8'h0, q}, 16'h0000);
    do_rd(2'd1, q);
    chk("R6 snapshot", {8'h0, q}, 16'h005A);
    do_wr(2'd1, 8'hAB);
    do_wr(2'd0, 8'hCD);
    do_wr(2'd2, 8'h00);
    rd16(v);
    chk("R7 atomic commit", v, 16'hABCD);

    // R6: snapshot while counting
    do_wr(2'd0, 8'hFF);
    do_wr(2'd1, 8'h01);
    do_wr(2'd2, 8'h81);
    @(negedge clk);
    bus_sel = 2'd0; bus_rd = 1'b1; tick_en = 1'b1;
    #1 q = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; tick_en = 1'b0;
    chk("R6 lo at snapshot", {8'h0, q}, 16'h00FF);
    do_rd(2'd1, q);
    chk("R6 consistent hi", {8'h0, q}, 16'h0001);
    do_wr(2'd2, 8'h00);
    do_rd(2'd1, q);
    chk("R1 live hi advanced", {8'h0, q}, 16'h0002);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule